// File: doc/BRIEF.md
# Byte Arithmetic Unit with Condition Flags

This block performs 8-bit binary addition and subtraction and a decimal correction step for packed BCD. It keeps an 8-bit flag register that records carry/borrow, sign, zero, signed overflow and nibble carry. The result byte follows the operands combinationally. The flag register is updated on the clock edge when the unit is enabled.

A controller chooses one of four operations with a 2-bit select. Operand `a` is the accumulator-side value and operand `b` is the second value. Multi-byte sums chain through the add-with-carry operation, which takes the stored carry as its carry-in. After a BCD addition, the decimal correction is applied to the sum. It uses the stored nibble-carry and carry flags to turn the binary sum into two valid decimal digits. The three control bits that arithmetic does not touch live in the same register and change only when the whole byte is written through the direct load path.

Top module: `alu8_cc`

## Requirements
- R1: The flag register `cc` is laid out with bit 7 = E, 6 = F, 5 = H, 4 = I, 3 = N, 2 = Z, 1 = V, 0 = C. A synchronous active-high `rst` clears it to 0x00.
- R2: With `op` = 2'b00 (add), `result` = (a + b) mod 256. After the enabled edge, C holds bit 8 of the sum.
- R3: With `op` = 2'b01 (add with carry), `result` = (a + b + C) mod 256, using the stored C. After the edge, C holds bit 8 of that sum.
- R4: With `op` = 2'b10 (subtract), `result` = (a - b) mod 256. After the edge, C is 1 exactly when a < b as unsigned values (borrow).
- R5: After any enabled operation, N equals bit 7 of `result` and Z is 1 exactly when `result` is zero.
- R6: On add, add-with-carry and subtract, V is set exactly when the signed result leaves the range -128..127.
- R7: On add and add-with-carry, H is the carry out of bit 3, including the carry-in. Subtract and decimal correction leave H unchanged.
- R8: With `op` = 2'b11 (decimal correction of `a`), step one adds 0x06 if H = 1 or the low nibble of `a` exceeds 9, giving a 9-bit t. Step two adds 0x60 to t's low byte if C = 1, t's bit 8 is set, or t's high nibble exceeds 9. `result` is that byte mod 256.
- R9: After decimal correction, C is 1 exactly when the 0x60 step applied, and V is unchanged.
- R10: E, F and I never change through an operation. `cc_load` = 1 writes all eight bits from `cc_din` and takes priority over `en`.
- R11: With `en` = 0 and `cc_load` = 0, the flag register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Commit the selected operation's flags on this edge |
| op | input | 2 | Operation: 00 add, 01 add with carry, 10 subtract, 11 decimal correction |
| a | input | 8 | First operand, and the value corrected in decimal mode |
| b | input | 8 | Second operand, unused in decimal mode |
| cc_load | input | 1 | Write the whole flag register from `cc_din` |
| cc_din | input | 8 | Value for the direct flag write |
| result | output | 8 | Operation result (combinational) |
| cc | output | 8 | Flag register |

## Verification
Plain addition is swept over every first operand against a stride of second operands. The flag byte preloaded before each operation is derived from the operands, so every flag bit is seen both set and clear before the operation. This separates bits the operation must overwrite from E, F, I and, for subtraction, H, which must survive. Add-with-carry and subtraction are swept the same way. The varying preloaded C shows whether the stored carry is really consumed, and the signed and unsigned boundary pairs show borrow and overflow as separate conditions. Decimal correction is tried on all 256 bytes under all four H/C combinations, which distinguishes the low-digit trigger, the high-digit trigger and the cascade where the first step pushes the high digit past 9. Directed cases cover reset, load priority over enable, and holding with enable low.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW   = 8;
    localparam int NIB  = 4;
    localparam int NNIB = DW / NIB;
    localparam int MSB  = DW - 1;

    // Flag bit positions, fixed layout
    localparam int CC_E = 7;
    localparam int CC_F = 6;
    localparam int CC_H = 5;
    localparam int CC_I = 4;
    localparam int CC_N = 3;
    localparam int CC_Z = 2;
    localparam int CC_V = 1;
    localparam int CC_C = 0;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_ADC = 2'b01,
        OP_SUB = 2'b10,
        OP_DAA = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] val;
        logic          c;
        logic          h;
        logic          v;
    } arith_t;

    function automatic logic nib_over9(input logic [NIB-1:0] n);
        return n > NIB'(9);
    endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    output arith_t        res
);
    logic [DW-1:0] b_eff;
    logic [NNIB:0] cy;
    logic [DW-1:0] sum;

    assign b_eff = sub ? ~b : b;
    assign cy[0] = sub ? ~cin : cin;

    // Nibble-wide carry chain; nibble carries expose the half carry
    for (genvar i = 0; i < NNIB; i++) begin : g_nib
        logic [NIB:0] part;
        assign part = {1'b0, a[i*NIB +: NIB]} + {1'b0, b_eff[i*NIB +: NIB]}
                      + {{NIB{1'b0}}, cy[i]};
        assign sum[i*NIB +: NIB] = part[NIB-1:0];
        assign cy[i+1]           = part[NIB];
    end

    always_comb begin
        res.val = sum;
        res.c   = sub ? ~cy[NNIB] : cy[NNIB];
        res.h   = cy[1];
        res.v   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] a,
    input  logic          h_in,
    input  logic          c_in,
    output logic [DW-1:0] val,
    output logic          c_out
);
    logic          lo_fix;
    logic          hi_fix;
    logic [DW:0]   stage1;

    always_comb begin
        lo_fix = h_in || nib_over9(a[NIB-1:0]);
        stage1 = {1'b0, a} + (lo_fix ? (DW+1)'(9'h006) : '0);
        hi_fix = c_in || stage1[DW] || nib_over9(stage1[DW-1:DW-NIB]);
        val    = stage1[DW-1:0] + (hi_fix ? DW'(8'h60) : '0);
        c_out  = hi_fix;
    end

    // Incoming carry always forces the high correction and a carry out
    p_carry_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        c_in |-> c_out);
    // Plain BCD input without flags needs no correction at all
    p_valid_bcd_r8: assert property (@(posedge clk) disable iff (rst)
        (!h_in && !c_in && !nib_over9(a[NIB-1:0]) && !nib_over9(a[DW-1:DW-NIB]))
        |-> (val == a && !c_out));
endmodule

// File: rtl/alu8_ccreg.sv
module alu8_ccreg
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] nxt,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= din;
        else if (en)   q <= nxt;
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (q == '0));
    p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(din)));
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!load && !en) |=> $stable(q));
    p_ctrl_bits_r10: assert property (@(posedge clk) disable iff (rst)
        !load |=> (q[CC_E] == $past(q[CC_E]) && q[CC_F] == $past(q[CC_F])
                   && q[CC_I] == $past(q[CC_I])));
endmodule

// File: rtl/alu8_cc.sv
module alu8_cc
    import alu8_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] op,
    input  logic [7:0] a,
    input  logic [7:0] b,
    input  logic       cc_load,
    input  logic [7:0] cc_din,
    output logic [7:0] result,
    output logic [7:0] cc
);
    alu_op_e       op_s;
    arith_t        bin;
    logic [DW-1:0] dec_val;
    logic          dec_c;
    logic [DW-1:0] cc_q;
    logic [DW-1:0] cc_nxt;

    assign op_s = alu_op_e'(op);

    alu8_addsub u_addsub (
        .a   (a),
        .b   (b),
        .cin ((op_s == OP_ADC) ? cc_q[CC_C] : 1'b0),
        .sub (op_s == OP_SUB),
        .res (bin)
    );

    alu8_decadj u_decadj (
        .clk   (clk),
        .rst   (rst),
        .a     (a),
        .h_in  (cc_q[CC_H]),
        .c_in  (cc_q[CC_C]),
        .val   (dec_val),
        .c_out (dec_c)
    );

    always_comb begin
        cc_nxt = cc_q;
        if (op_s == OP_DAA) begin
            result       = dec_val;
            cc_nxt[CC_C] = dec_c;
        end else begin
            result       = bin.val;
            cc_nxt[CC_C] = bin.c;
            cc_nxt[CC_V] = bin.v;
            if (op_s != OP_SUB) cc_nxt[CC_H] = bin.h;
        end
        cc_nxt[CC_N] = result[MSB];
        cc_nxt[CC_Z] = (result == '0);
    end

    alu8_ccreg u_ccreg (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .load (cc_load),
        .din  (cc_din),
        .nxt  (cc_nxt),
        .q    (cc_q)
    );

    assign cc = cc_q;

    p_zero_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (en && !cc_load) |=> (cc_q[CC_Z] == ($past(result) == '0)));
    p_neg_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (en && !cc_load) |=> (cc_q[CC_N] == $past(result[MSB])));
    p_sub_keeps_h_r7: assert property (@(posedge clk) disable iff (rst)
        (en && !cc_load && (op_s == OP_SUB || op_s == OP_DAA))
        |=> (cc_q[CC_H] == $past(cc_q[CC_H])));
    p_daa_keeps_v_r9: assert property (@(posedge clk) disable iff (rst)
        (en && !cc_load && op_s == OP_DAA) |=> (cc_q[CC_V] == $past(cc_q[CC_V])));
endmodule

// File: tb/sim_alu8_cc.sv
module sim_alu8_cc;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [1:0] op = 2'b00;
    logic [7:0] a = 8'h00;
    logic [7:0] b = 8'h00;
    logic       cc_load = 1'b0;
    logic [7:0] cc_din = 8'h00;
    logic [7:0] result;
    logic [7:0] cc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alu8_cc u0 (
        .clk(clk), .rst(rst), .en(en), .op(op), .a(a), .b(b),
        .cc_load(cc_load), .cc_din(cc_din), .result(result), .cc(cc)
    );

    // Expected model: returns {result, cc_after}
    function automatic logic [15:0] model(input logic [1:0] o, input logic [7:0] x,
                                          input logic [7:0] y, input logic [7:0] pre);
        logic [7:0] r;
        logic [7:0] f;
        int s;
        int t;
        int ci;
        logic hi;
        f = pre;
        ci = (o == 2'b01) ? int'(pre[0]) : 0;
        if (o == 2'b10) begin
            s = int'(x) - int'(y);
            r = s[7:0];
            f[0] = (x < y);
            f[1] = (x[7] != y[7]) && (r[7] != x[7]);
        end else if (o == 2'b11) begin
            t = int'(x) + (((x & 8'h0F) > 9 || pre[5]) ? 6 : 0);
            hi = pre[0] || (t > 255) || (((t >> 4) & 15) > 9);
            s = (t & 255) + (hi ? 96 : 0);
            r = s[7:0];
            f[0] = hi;
        end else begin
            s = int'(x) + int'(y) + ci;
            r = s[7:0];
            f[0] = (s > 255);
            f[1] = (x[7] == y[7]) && (r[7] != x[7]);
            f[5] = ((int'(x & 8'h0F) + int'(y & 8'h0F) + ci) > 15);
        end
        f[3] = r[7];
        f[2] = (r == 8'h00);
        return {r, f};
    endfunction

    function automatic string op_tag(input logic [1:0] o);
        case (o)
            2'b00: return "R2";
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R8";
        endcase
    endfunction

    function automatic string bit_tag(input int i, input logic [1:0] o);
        case (i)
            7, 6, 4: return "R10";
            5: return "R7";
            3, 2: return "R5";
            1: return (o == 2'b11) ? "R9" : "R6";
            default: return (o == 2'b11) ? "R9" : op_tag(o);
        endcase
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Preload flags, run one operation, check result then flags
    task automatic run_op(input logic [1:0] o, input logic [7:0] x,
                          input logic [7:0] y, input logic [7:0] pre);
        logic [15:0] e;
        e = model(o, x, y, pre);
        @(negedge clk);
        cc_load = 1'b1; cc_din = pre; en = 1'b0;
        @(negedge clk);
        cc_load = 1'b0; en = 1'b1; op = o; a = x; b = y;
        #1;
        check8(op_tag(o), result, e[15:8]);
        @(negedge clk);
        en = 1'b0;
        checks++;
        if (cc !== e[7:0]) begin
            failures++;
            for (int i = 0; i < 8; i++)
                if (cc[i] !== e[i])
                    $display("FAIL %s op=%0d a=%02h b=%02h pre=%02h cc actual=%02h expected=%02h",
                             bit_tag(i, o), o, x, y, pre, cc, e[7:0]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check8("R1 reset", cc, 8'h00);

        // Worked examples
        run_op(2'b00, 8'hF3, 8'h0E, 8'h00);   // R2
        run_op(2'b10, 8'h56, 8'h63, 8'h00);   // R4 borrow
        run_op(2'b10, 8'h66, 8'h63, 8'h00);   // R4 no borrow
        run_op(2'b00, 8'h19, 8'h85, 8'h00);   // R7 sum 9E
        run_op(2'b11, 8'h9E, 8'h00, 8'h00);   // R8 -> 04, C=1
        run_op(2'b00, 8'h7F, 8'h01, 8'hD0);   // R6 signed overflow, R10 keeps E F I
        run_op(2'b10, 8'h80, 8'h01, 8'h00);   // R6 subtract overflow

        // R10: load beats enable
        @(negedge clk);
        cc_load = 1'b1; cc_din = 8'hA5; en = 1'b1; op = 2'b00; a = 8'h00; b = 8'h00;
        @(negedge clk);
        cc_load = 1'b0; en = 1'b0;
        check8("R10 load priority", cc, 8'hA5);

        // R11: disabled operation leaves flags alone
        op = 2'b00; a = 8'hFF; b = 8'h01;
        @(negedge clk);
        @(negedge clk);
        check8("R11 hold", cc, 8'hA5);

        // Sweeps
        for (int x = 0; x < 256; x++)
            for (int y = 0; y < 256; y += 3)
                run_op(2'b00, 8'(x), 8'(y), 8'(x) ^ {8'(y) << 4 | 8'(y) >> 4} ^ 8'h5A);
        for (int x = 0; x < 256; x++)
            for (int y = 0; y < 256; y += 5)
                run_op(2'b01, 8'(x), 8'(y), 8'(x + y) ^ 8'h3C);
        for (int x = 0; x < 256; x++)
            for (int y = 0; y < 256; y += 5)
                run_op(2'b10, 8'(x), 8'(y), 8'(x) ^ 8'(y * 7) ^ 8'hC3);
        for (int x = 0; x < 256; x++)
            for (int hc = 0; hc < 4; hc++)
                run_op(2'b11, 8'(x), 8'h00, {2'b10, hc[1], 4'b1010, hc[0]});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule